// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on one transmit line. The line is high when idle. Each frame has a low start bit, then the data bits with the lowest bit first, then an optional parity bit, then one or two high stop bits. Every bit lasts from one baud tick to the next. The baud-tick enable comes from outside the block, because rate generation is not part of it.

Words enter through a valid/ready handshake into a single holding register. The frame format is captured together with each word when the word is accepted, so each frame can use its own format:

- data length from 5 to 9 bits,
- parity none, even or odd,
- one or two stop bits.

When the holding register is already loaded at the moment the last stop bit ends, the next start bit follows on that tick with no idle gap. Otherwise the line returns to idle high.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame begins at a baud tick with exactly one start bit, driven low for one tick period.
- R2: `cfg_len` selects the data length as 5 + `cfg_len` bits for codes 0 to 4. Codes 5 to 7 select 9 bits.
- R3: Data bits are sent least-significant first, one per tick period. Data bits above the selected length are never sent.
- R4: `cfg_parity` code 0 or 3 sends no parity bit. Code 1 (even) makes the number of ones in the sent data bits plus the parity bit even. Code 2 (odd) makes that number odd.
- R5: When parity is enabled, the parity bit comes right after the last data bit and before the first stop bit.
- R6: After the data bits (and the parity bit, if present), the line is driven high for one stop bit when `cfg_two_stop` is 0, and for two stop bits when it is 1.
- R7: A word that is waiting when the last stop bit ends has its start bit sent on that same tick, with no idle period between the frames.
- R8: The format inputs are captured at acceptance (`in_valid` and `in_ready` high at a clock edge). Changing them afterwards does not alter that word's frame.
- R9: The holding register stores one word. `in_ready` is high after reset and goes low in the cycle after a word is accepted. It stays low until that word's start bit begins.
- R10: `tx_busy` is high from the start bit through the last stop bit and low otherwise. This includes the time a word waits in the holding register.
- R11: After reset, and whenever no frame is in progress, `tx_out` is high.
- R12: `tx_out` and `tx_busy` change only at clock edges where `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Word to send, bit 0 sent first |
| in_valid | input | 1 | Word and format are valid |
| in_ready | output | 1 | Holding register is empty |
| cfg_len | input | 3 | Data length code (5 + code bits, capped at 9) |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| baud_tick | input | 1 | One-clock pulse marking a bit boundary |
| tx_out | output | 1 | Serial line, registered, idles high |
| tx_busy | output | 1 | Frame in progress, registered |

## Verification
A wrong bit counter, shift register or parity flag changes the line within one tick period of the faulty bit. Every later bit of that frame then reads as misaligned, and the misalignment spreads into the frames that follow. A sequencer that loses track of the holding register either leaves the line idle while a word waits, which shows up as an inserted gap or a stream that never drains, or it sends a frame twice. The bench checks the sampled line in the middle of every tick period against a bit stream it builds from the requirements, so an error appears at the first bad bit. A change of the line between ticks is caught in the same period.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int LEN_W    = 3;
  localparam int MIN_BITS = 5;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_mode_t;

  typedef struct packed {
    logic [LEN_W-1:0] len_code;
    par_mode_t        par;
    logic             two_stop;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4
  } tx_state_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  frame_cfg_t        push_cfg,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] hold_data,
  output frame_cfg_t        hold_cfg
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  frame_cfg_t        cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
      cfg_q  <= '0;
    end else if (push_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= push_data;
      cfg_q  <= push_cfg;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

  assign push_ready = !full_q;
  assign full       = full_q;
  assign hold_data  = data_q;
  assign hold_cfg   = cfg_q;

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter  int DATA_W = 9,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  nbits,
  input  par_mode_t         mode,
  output logic              par_en,
  output logic              par_bit
);

  logic [DATA_W-1:0] mask;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
    assign mask[gi] = (nbits > CNT_W'(gi));
  end

  assign par_en  = (mode == PAR_EVEN) || (mode == PAR_ODD);
  assign par_bit = (^(data & mask)) ^ (mode == PAR_ODD);

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter  int DATA_W = 9,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              avail,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [CNT_W-1:0]  ld_nbits,
  input  logic              ld_par_en,
  input  logic              ld_par_bit,
  input  logic              ld_two_stop,
  output logic              pop,
  output logic              tx_out,
  output logic              tx_busy
);

  tx_state_t         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bits_left;
  logic              par_en_q;
  logic              par_bit_q;
  logic              two_q;
  logic              stop_more;
  logic              tx_q;
  logic              busy_q;
  logic              last_stop;

  assign last_stop = (state == S_STOP) && !stop_more;
  assign pop       = baud_tick && avail && ((state == S_IDLE) || last_stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      shreg     <= '0;
      bits_left <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      two_q     <= 1'b0;
      stop_more <= 1'b0;
      tx_q      <= 1'b1;
      busy_q    <= 1'b0;
    end else if (pop) begin
      state     <= S_START;
      shreg     <= ld_data;
      bits_left <= ld_nbits;
      par_en_q  <= ld_par_en;
      par_bit_q <= ld_par_bit;
      two_q     <= ld_two_stop;
      stop_more <= 1'b0;
      tx_q      <= 1'b0;
      busy_q    <= 1'b1;
    end else if (baud_tick) begin
      case (state)
        S_START: begin
          state     <= S_DATA;
          tx_q      <= shreg[0];
          shreg     <= shreg >> 1;
          bits_left <= bits_left - 1'b1;
        end
        S_DATA: begin
          if (bits_left != '0) begin
            tx_q      <= shreg[0];
            shreg     <= shreg >> 1;
            bits_left <= bits_left - 1'b1;
          end else if (par_en_q) begin
            state <= S_PAR;
            tx_q  <= par_bit_q;
          end else begin
            state     <= S_STOP;
            tx_q      <= 1'b1;
            stop_more <= two_q;
          end
        end
        S_PAR: begin
          state     <= S_STOP;
          tx_q      <= 1'b1;
          stop_more <= two_q;
        end
        S_STOP: begin
          if (stop_more) begin
            stop_more <= 1'b0;
          end else begin
            state  <= S_IDLE;
            tx_q   <= 1'b1;
            busy_q <= 1'b0;
          end
        end
        default: begin
          tx_q <= 1'b1;
        end
      endcase
    end
  end

  assign tx_out  = tx_q;
  assign tx_busy = busy_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter  int DATA_W = 9,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  input  logic              baud_tick,
  output logic              tx_out,
  output logic              tx_busy
);

  frame_cfg_t        in_cfg;
  frame_cfg_t        hold_cfg;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              pop;
  logic [CNT_W-1:0]  nbits;
  logic              par_en;
  logic              par_bit;

  assign in_cfg = '{len_code: cfg_len, par: par_mode_t'(cfg_parity), two_stop: cfg_two_stop};

  uart_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk        (clk),
    .rst        (rst),
    .push_valid (in_valid),
    .push_ready (in_ready),
    .push_data  (in_data),
    .push_cfg   (in_cfg),
    .pop        (pop),
    .full       (hold_full),
    .hold_data  (hold_data),
    .hold_cfg   (hold_cfg)
  );

  always_comb begin
    if (int'(hold_cfg.len_code) >= DATA_W - MIN_BITS) begin
      nbits = CNT_W'(DATA_W);
    end else begin
      nbits = CNT_W'(hold_cfg.len_code) + CNT_W'(MIN_BITS);
    end
  end

  uart_tx_parity #(.DATA_W(DATA_W)) i_parity (
    .data    (hold_data),
    .nbits   (nbits),
    .mode    (hold_cfg.par),
    .par_en  (par_en),
    .par_bit (par_bit)
  );

  uart_tx_seq #(.DATA_W(DATA_W)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .baud_tick   (baud_tick),
    .avail       (hold_full),
    .ld_data     (hold_data),
    .ld_nbits    (nbits),
    .ld_par_en   (par_en),
    .ld_par_bit  (par_bit),
    .ld_two_stop (hold_cfg.two_stop),
    .pop         (pop),
    .tx_out      (tx_out),
    .tx_busy     (tx_busy)
  );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic baud_tick,
  input logic tx_out,
  input logic tx_busy
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst) !tx_busy |-> tx_out); // R11
  AST_START_IS_LOW: assert property (@(posedge clk) disable iff (rst) $rose(tx_busy) |-> !tx_out); // R1
  AST_END_AFTER_STOP: assert property (@(posedge clk) disable iff (rst) $fell(tx_busy) |-> $past(tx_out)); // R6
  AST_LINE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst) !baud_tick |=> $stable(tx_out)); // R12
  AST_BUSY_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst) !baud_tick |=> $stable(tx_busy)); // R12
  AST_HOLD_ONE_ENTRY: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready) |=> !in_ready); // R9

endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .baud_tick (baud_tick),
  .tx_out    (tx_out),
  .tx_busy   (tx_busy)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    cfg_len = '0;
  logic [1:0]    cfg_parity = '0;
  logic          cfg_two_stop = 1'b0;
  logic          baud_tick = 1'b0;
  logic          tx_out;
  logic          tx_busy;

  int n_checks = 0;
  int n_fail   = 0;
  int ph       = 0;
  int gaps     = 0;
  int cycles   = 0;
  bit prev_frame = 1'b0;
  bit mid_val    = 1'b1;
  bit done       = 1'b0;

  bit    exp_bit[$];
  bit    exp_start[$];
  string exp_tag[$];

  always #5 clk = ~clk;

  uart_frame_tx #(.DATA_W(DW)) i_uart_frame_tx (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .baud_tick(baud_tick), .tx_out(tx_out), .tx_busy(tx_busy)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // tick generator and mid-bit line monitor
  always @(negedge clk) begin
    if (rst) begin
      ph = 0;
      baud_tick = 1'b0;
    end else begin
      if (ph == 2) begin
        mid_val = tx_out;
        if (exp_bit.size() == 0) begin
          chk(tx_out == 1'b1, "R11", "idle line", int'(tx_out), 1);
          chk(tx_busy == 1'b0, "R10", "busy when idle", int'(tx_busy), 0);
          prev_frame = 1'b0;
        end else if (exp_start[0] && tx_out == 1'b1) begin
          if (prev_frame) gaps++;
          chk(tx_busy == 1'b0, "R10", "busy while waiting", int'(tx_busy), 0);
          prev_frame = 1'b0;
        end else begin
          chk(tx_out == exp_bit[0], exp_tag[0], "line bit", int'(tx_out), int'(exp_bit[0]));
          chk(tx_busy == 1'b1, "R10", "busy in frame", int'(tx_busy), 1);
          void'(exp_bit.pop_front());
          void'(exp_start.pop_front());
          void'(exp_tag.pop_front());
          prev_frame = 1'b1;
        end
      end else if (ph == 3) begin
        chk(tx_out == mid_val, "R12", "line moved between ticks", int'(tx_out), int'(mid_val));
      end
      ph = (ph == 3) ? 0 : ph + 1;
      baud_tick = (ph == 0);
    end
  end

  task automatic add_bit(input bit b, input bit st, input string tag);
    exp_bit.push_back(b);
    exp_start.push_back(st);
    exp_tag.push_back(tag);
  endtask

  task automatic send(input logic [DW-1:0] d, input int code, input int par, input bit two,
                      input string over);
    int n;
    bit p;
    n = (code >= DW - 5) ? DW : code + 5;
    while (!in_ready) @(negedge clk);
    in_data = d; cfg_len = 3'(code); cfg_parity = 2'(par); cfg_two_stop = two;
    in_valid = 1'b1;
    add_bit(1'b0, 1'b1, (over != "") ? over : "R1");
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      add_bit(d[i], 1'b0, (over != "") ? over : "R2 R3");
      p = p ^ d[i];
    end
    if (par == 1) add_bit(p, 1'b0, (over != "") ? over : "R4 R5");
    if (par == 2) add_bit(~p, 1'b0, (over != "") ? over : "R4 R5");
    add_bit(1'b1, 1'b0, (over != "") ? over : "R6");
    if (two) add_bit(1'b1, 1'b0, (over != "") ? over : "R6");
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R9", "ready after accept", int'(in_ready), 0);
    // scramble format inputs after acceptance
    in_data = ~d; cfg_len = 3'(code + 3); cfg_parity = 2'(par + 1); cfg_two_stop = ~two;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_bit.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] pats[5];
    logic [DW-1:0] lf;
    pats[0] = 9'h000; pats[1] = 9'h1FF; pats[2] = 9'h155; pats[3] = 9'h0AA;
    lf = 9'h0B3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(tx_out == 1'b1, "R11", "reset line", int'(tx_out), 1);
    chk(tx_busy == 1'b0, "R10", "reset busy", int'(tx_busy), 0);
    chk(in_ready == 1'b1, "R9", "reset ready", int'(in_ready), 1);
    repeat (10) @(negedge clk);

    // full sweep of formats, frames pushed back to back
    gaps = 0;
    for (int c = 0; c < 5; c++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 5; k++) begin
            if (k == 4) begin
              lf = {lf[DW-2:0], lf[8] ^ lf[4]};
              pats[4] = lf;
            end
            send(pats[k], c, p, s[0], "");
          end
    send(9'h1A5, 7, 1, 1'b0, "R2");
    send(9'h0F3, 3, 3, 1'b1, "R4");
    drain();
    chk(gaps == 0, "R7", "idle gaps between queued frames", gaps, 0);
    chk(exp_bit.size() == 0, "R7", "frames left unsent", exp_bit.size(), 0);

    // format change right after acceptance must not affect the frame
    send(9'h0C9, 3, 1, 1'b0, "R8");
    cfg_len = 3'd0; cfg_parity = 2'd2; cfg_two_stop = 1'b1;
    drain();
    chk(exp_bit.size() == 0, "R8", "frame drained", exp_bit.size(), 0);

    // isolated frames with idle time between them
    send(9'h011, 0, 2, 1'b1, "");
    drain();
    chk(tx_out == 1'b1, "R11", "line after frame", int'(tx_out), 1);
    chk(tx_busy == 1'b0, "R10", "busy after frame", int'(tx_busy), 0);
    send(9'h1FE, 4, 0, 1'b0, "");
    drain();
    chk(exp_bit.size() == 0, "R1", "late frame drained", exp_bit.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule